// File: doc/BRIEF.md
# H-Bridge PWM Polarity Decoder

This block turns per-channel drive settings into gate-level states for the two half-bridges of four brushed-DC or voice-coil motor channels. Each half-bridge can be driven high, driven low, or left off (high impedance). Each channel has a 2-bit polarity code. A decay-mode select decides what the high phase of a PWM signal does: it either brakes the winding or lets it coast.

All channels share one external pin. A configuration bit makes that pin a PWM source. When the bit is clear, the pin is a step clock for a neighbouring stepper sequencer. An allocation field decides which channels the PWM source reaches. Channels 0 and 1 can take PWM singly or together. Channel 2 takes it on its own. Channel 3 never takes PWM. Instead, a dedicated enable pin gates channel 3.

Both external pins pass through a synchroniser of SYNC_STAGES flops before they are used. All outputs are registered. The PWM source may toggle at up to 100 kHz, which is far slower than the block clock.

Top module: `hbridge_pwm_decoder`

## Requirements
- R1: Output encoding: `out_oe[2k]` and `out_lvl[2k]` belong to side A of channel k, and `out_oe[2k+1]` and `out_lvl[2k+1]` belong to side B. A side with oe=0 is off and always shows lvl=0. With PWM not applied, the polarity code decodes as follows. 2'b00 turns both sides off. 2'b10 drives A high and B low. 2'b01 drives A low and B high. 2'b11 drives both sides low (brake).
- R2: With `decay_fast`=0, a high PWM on a channel that receives it drives both sides of that channel low, whatever its code.
- R3: With `decay_fast`=1, a high PWM on channel 0 or channel 1 turns both sides of that channel off, whatever its code.
- R4: With `decay_fast`=1, a high PWM on channel 2 gives brake (both sides low) for code 2'b11. For every other code, both sides are off.
- R5: The allocation field decides which channels receive PWM. If `pwm_alloc[2]`=1, only channel 2 receives it. Otherwise `pwm_alloc[0]` routes PWM to channel 0 and `pwm_alloc[1]` routes it to channel 1.
- R6: A channel that does not receive PWM ignores the pin and decodes its code as in R1. Channel 3 never receives PWM.
- R7: With `pin_is_pwm`=0, the pin reaches no channel as PWM, and `step_clk` follows the synchronised pin. With `pin_is_pwm`=1, `step_clk` stays 0.
- R8: On channel 3, a low synchronised `ch3_en` turns both sides off. A high `ch3_en` lets `pol_d` decode as in R1.
- R9: With SYNC_STAGES=2, a change on `drv_pin` or `ch3_en` reaches the outputs on the third rising clock edge after it. A change on a code or configuration input reaches the outputs on the first rising edge.
- R10: While `rst_n` is low, every side is off and `step_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_pin | input | 1 | Shared external pin (PWM source or step clock) |
| ch3_en | input | 1 | External enable for channel 3 |
| pin_is_pwm | input | 1 | 1: pin is PWM, 0: pin is step clock |
| decay_fast | input | 1 | 1: PWM high coasts, 0: PWM high brakes |
| pwm_alloc | input | 3 | PWM routing field (R5) |
| pol_a | input | 2 | Polarity code, channel 0 |
| pol_b | input | 2 | Polarity code, channel 1 |
| pol_c | input | 2 | Polarity code, channel 2 |
| pol_d | input | 2 | Polarity code, channel 3 |
| out_oe | output | 8 | Per-side drive enable |
| out_lvl | output | 8 | Per-side drive level |
| step_clk | output | 1 | Synchronised pin when used as step clock |

## Verification
The bench sweeps every combination of pin role, decay mode, all eight allocation values, pin level, a rotating set of polarity codes and the channel 3 enable. This sweep separates brake from coast, and the paired channels from channel 2 in fast decay. It also shows that unallocated channels are unaffected by a high pin. Because the codes rotate across the channels, a channel-swapped route or decode shows up as a mismatch. Directed sequences cover the step-clock path in both pin roles, and they measure the exact edge on which register and pin changes appear, which exposes a missing or extra synchroniser stage.

// File: rtl/hbridge_pwm_decoder.sv
module hbridge_pwm_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_pin,
  input  logic       ch3_en,
  input  logic       pin_is_pwm,
  input  logic       decay_fast,
  input  logic [2:0] pwm_alloc,
  input  logic [1:0] pol_a,
  input  logic [1:0] pol_b,
  input  logic [1:0] pol_c,
  input  logic [1:0] pol_d,
  output logic [7:0] out_oe,
  output logic [7:0] out_lvl,
  output logic       step_clk
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] pin_sr, en_sr;
  logic         pwm_s, en_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_sr <= '0;
      en_sr  <= '0;
    end else begin
      pin_sr <= {pin_sr[TOP-1:0], drv_pin};
      en_sr  <= {en_sr[TOP-1:0], ch3_en};
    end

  assign pwm_s = pin_sr[TOP];
  assign en_s  = en_sr[TOP];

  // returns {oe_b, oe_a, lvl_b, lvl_a}
  function automatic logic [3:0] side_pair(input logic [1:0] code, input logic pwm_on,
                                           input logic fast, input logic keep_brake);
    if (pwm_on && !fast)                          return 4'b1100;
    if (pwm_on && !(keep_brake && code == 2'b11)) return 4'b0000;
    case (code)
      2'b10:   return 4'b1101;
      2'b01:   return 4'b1110;
      2'b11:   return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  logic       pwm_live, on_a, on_b, on_c;
  logic [3:0] d_a, d_b, d_c, d_d;

  assign pwm_live = pin_is_pwm & pwm_s;
  assign on_a     = pwm_live & ~pwm_alloc[2] & pwm_alloc[0];
  assign on_b     = pwm_live & ~pwm_alloc[2] & pwm_alloc[1];
  assign on_c     = pwm_live &  pwm_alloc[2];

  assign d_a = side_pair(pol_a, on_a, decay_fast, 1'b0);
  assign d_b = side_pair(pol_b, on_b, decay_fast, 1'b0);
  assign d_c = side_pair(pol_c, on_c, decay_fast, 1'b1);
  assign d_d = en_s ? side_pair(pol_d, 1'b0, decay_fast, 1'b0) : 4'b0000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_oe   <= '0;
      out_lvl  <= '0;
      step_clk <= 1'b0;
    end else begin
      out_oe   <= {d_d[3:2], d_c[3:2], d_b[3:2], d_a[3:2]};
      out_lvl  <= {d_d[1:0], d_c[1:0], d_b[1:0], d_a[1:0]};
      step_clk <= pwm_s & ~pin_is_pwm;
    end
endmodule

module hbridge_pwm_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_is_pwm,
  input logic       decay_fast,
  input logic [2:0] pwm_alloc,
  input logic [1:0] pol_b,
  input logic       pwm_s,
  input logic       en_s,
  input logic [7:0] out_oe,
  input logic [7:0] out_lvl,
  input logic       step_clk
);
  a_r1_off_level_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_lvl & ~out_oe) == 8'h00);

  a_r2_slow_brake: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && pin_is_pwm && pwm_s && !decay_fast && pwm_alloc == 3'b001)
    |-> (out_oe[1:0] == 2'b11 && out_lvl[1:0] == 2'b00));

  a_r3_fast_coast: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && pin_is_pwm && pwm_s && decay_fast && pwm_alloc == 3'b001)
    |-> out_oe[1:0] == 2'b00);

  a_r6_unalloc_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && pwm_alloc == 3'b001 && pol_b == 2'b10)
    |-> (out_oe[3:2] == 2'b11 && out_lvl[3:2] == 2'b01));

  a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !en_s) |-> out_oe[7:6] == 2'b00);

  a_r7_step_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && pin_is_pwm) |-> !step_clk);
endmodule

bind hbridge_pwm_decoder hbridge_pwm_decoder_chk u_chk (.*);

// File: tb/hbridge_pwm_decoder_bench.sv
`timescale 1ns/1ps
module hbridge_pwm_decoder_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       drv_pin = 0, ch3_en = 0, pin_is_pwm = 0, decay_fast = 0;
  logic [2:0] pwm_alloc = 0;
  logic [1:0] pol_a = 2'b10, pol_b = 2'b10, pol_c = 2'b10, pol_d = 2'b10;
  logic [7:0] out_oe, out_lvl;
  logic       step_clk;
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  hbridge_pwm_decoder u_hbridge_pwm_decoder (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {oe_b, oe_a, lvl_b, lvl_a} from the requirement text
  function automatic logic [3:0] model(input int ch, input logic [1:0] code, input logic ip,
                                       input logic pin, input logic fast, input logic [2:0] al,
                                       input logic en);
    logic gets;
    gets = ip && pin && ((ch == 2 && al[2]) || (ch == 0 && !al[2] && al[0]) ||
                         (ch == 1 && !al[2] && al[1]));
    if (ch == 3 && !en) return 4'b0000;
    if (gets && !fast) return 4'b1100;
    if (gets && fast) return (ch == 2 && code == 2'b11) ? 4'b1100 : 4'b0000;
    case (code)
      2'b10: return 4'b1101;
      2'b01: return 4'b1110;
      2'b11: return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    drv_pin = 1; ch3_en = 1; pin_is_pwm = 0;
    repeat (4) @(negedge clk);
    check(out_oe, 8'h00, "R10 oe in reset");
    check(out_lvl, 8'h00, "R10 lvl in reset");
    check(step_clk, 1'b0, "R10 step_clk in reset");
    drv_pin = 0; rst_n = 1;

    for (int ip = 0; ip < 2; ip++)
      for (int f = 0; f < 2; f++)
        for (int al = 0; al < 8; al++)
          for (int pv = 0; pv < 2; pv++)
            for (int p = 0; p < 4; p++)
              for (int e = 0; e < 2; e++) begin
                logic [1:0] codes [4];
                for (int c = 0; c < 4; c++) codes[c] = 2'(p + c);
                pin_is_pwm = 1'(ip); decay_fast = 1'(f); pwm_alloc = 3'(al);
                drv_pin = 1'(pv); ch3_en = 1'(e);
                pol_a = codes[0]; pol_b = codes[1]; pol_c = codes[2]; pol_d = codes[3];
                repeat (4) @(negedge clk);
                for (int c = 0; c < 4; c++) begin
                  logic [3:0] ex;
                  string tag;
                  ex = model(c, codes[c], 1'(ip), 1'(pv), 1'(f), 3'(al), 1'(e));
                  if (c == 3) tag = e ? "R8 enabled R1" : "R8 disabled";
                  else if (ex != model(c, codes[c], 1'b0, 1'b0, 1'(f), 3'(al), 1'(e)))
                    tag = f ? (c == 2 ? "R4 R5" : "R3 R5") : "R2 R5";
                  else if (pv && !ip) tag = "R7 pin not PWM";
                  else if (pv) tag = "R6 R5 unallocated";
                  else tag = "R1 decode";
                  check({out_oe[2*c+1], out_oe[2*c], out_lvl[2*c+1], out_lvl[2*c]}, ex,
                        $sformatf("%s ch%0d ip%0d f%0d al%0d pin%0d code%0d en%0d",
                                  tag, c, ip, f, al, pv, codes[c], e));
                end
              end

    pin_is_pwm = 0; drv_pin = 1; repeat (4) @(negedge clk);
    check(step_clk, 1'b1, "R7 step_clk follows pin high");
    drv_pin = 0; repeat (4) @(negedge clk);
    check(step_clk, 1'b0, "R7 step_clk follows pin low");
    pin_is_pwm = 1; drv_pin = 1; repeat (4) @(negedge clk);
    check(step_clk, 1'b0, "R7 step_clk blocked in PWM role");

    drv_pin = 0; pwm_alloc = 3'b001; decay_fast = 0; pol_a = 2'b00;
    repeat (4) @(negedge clk);
    pol_a = 2'b10; @(negedge clk);
    check(out_oe[1:0], 2'b11, "R9 code change after one edge");
    check(out_lvl[1:0], 2'b01, "R9 code change level after one edge");
    drv_pin = 1; repeat (2) @(negedge clk);
    check(out_lvl[1:0], 2'b01, "R9 pin not yet seen after two edges");
    @(negedge clk);
    check(out_lvl[1:0], 2'b00, "R9 pin seen after three edges (brake)");
    check(out_oe[1:0], 2'b11, "R9 R2 brake drive after three edges");

    ch3_en = 1; pol_d = 2'b01; repeat (4) @(negedge clk);
    ch3_en = 0; repeat (2) @(negedge clk);
    check(out_oe[7:6], 2'b11, "R9 enable not yet seen after two edges");
    @(negedge clk);
    check(out_oe[7:6], 2'b00, "R9 R8 enable drop seen after three edges");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule